// File: doc/BRIEF.md
# Fractional Clock Divider with First-Order Sigma-Delta Length Selection

The block produces a slower clock whose average period is a non-integer multiple of its source clock period. The requested ratio is given as an integer part N and an 8-bit fractional part F, read as F/256. Every output period is either N or N+1 source cycles long. At the start of each period a first-order sigma-delta accumulator adds F to its 8-bit state. A carry out of that sum makes the period N+1 cycles long. Over time the average ratio is N + F/256. With a 50 MHz source and a ratio of 6.25 (N=6, F=64), the output averages 8 MHz.

Each period is high for the first floor(length/2) cycles and low for the rest. A one-cycle flag marks the start of every lengthened period. An enable input models the clock gate that sits ahead of the divider: while it is low, the divider holds its state. The ratio inputs are sampled only at period boundaries, so a change never produces a truncated or stretched period.

Top module: `frac_clk_div`

## Requirements
- R1: Synchronous active-high reset drives `clk_out` and `long_flag` to 0 and clears the accumulator and the cycle counter. The first enabled edge after reset starts a period, computed from an accumulator value of 0.
- R2: Each output period is N+c cycles long. Here c is the carry out of the 8-bit sum of the accumulator and F, and the sum's low 8 bits become the new accumulator value.
- R3: For N=6 and F=64 (ratio 6.25), the periods repeat as 6, 6, 6, 7 starting from reset.
- R4: Within a period of length L, `clk_out` is 1 for the first floor(L/2) cycles and 0 for the remaining cycles.
- R5: `long_flag` is 1 only in the first cycle of a period of length N+1, which is also the first high cycle of `clk_out`. It is 0 in every other cycle.
- R6: While `en` is 0, the cycle counter, the accumulator and `clk_out` hold their values and `long_flag` is 0. When `en` returns to 1, the period continues from where it stopped.
- R7: `div_int` and `div_frac` are sampled only at a period boundary. A change during a period does not alter that period's length.
- R8: A `div_int` value below 2 is treated as 2.
- R9: With F=0, every period is exactly N cycles and `long_flag` stays 0.
- R10: Over any 256 consecutive periods after reset with a fixed ratio, the total length is 256·N + F cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low freezes the divider |
| div_int | input | 8 | Integer part N of the ratio |
| div_frac | input | 8 | Fractional part F of the ratio, in units of 1/256 |
| clk_out | output | 1 | Divided clock |
| long_flag | output | 1 | One-cycle mark at the start of an N+1 period |

## Verification
The assertions check the following on every cycle:
- the cycle counter stays inside the current period;
- the falling edge lands exactly at half the period length;
- the flag only ever coincides with a rising output edge;
- no carry occurs when F is zero;
- the output holds while disabled;
- the period length never drops below two.

Some behaviours need a sequence of periods, and only the bench scenarios can show them:
- whether the correct periods are lengthened (the 6.25 pattern and random ratios compared against a reference accumulator);
- that the 256-period sum works out exactly;
- that a mid-period ratio change waits for the boundary;
- that a frozen period resumes at the right position.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int INT_W   = 8;
    localparam int FRAC_W  = 8;
    localparam int LEN_W   = INT_W + 1;
    localparam int MIN_INT = 2;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [INT_W-1:0]  int_t;

    // one sigma-delta step: carry selects the long period
    typedef struct packed {
        logic  carry;
        frac_t sum;
    } sd_step_t;

    function automatic len_t base_len(int_t n);
        return (n < int_t'(MIN_INT)) ? len_t'(MIN_INT) : len_t'(n);
    endfunction

    function automatic len_t high_len(len_t l);
        return l >> 1;
    endfunction
endpackage

// File: rtl/fdiv_accum.sv
module fdiv_accum
    import fdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  frac_t frac,
    output logic  carry
);
    frac_t    acc_q;
    sd_step_t nxt;

    always_comb begin
        nxt   = sd_step_t'({1'b0, acc_q} + {1'b0, frac});
        carry = nxt.carry;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (step)
            acc_q <= nxt.sum;
    end

    // R9: a zero fraction can never lengthen a period
    a_r9_zero_frac_no_carry: assert property (@(posedge clk) disable iff (rst)
        (frac == '0) |-> !carry);
endmodule

// File: rtl/fdiv_period.sv
module fdiv_period
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  len_t base,
    input  logic carry,
    output logic boundary,
    output logic clk_out,
    output logic long_flag
);
    len_t pos_q;
    len_t len_q;
    len_t new_len;

    always_comb begin
        boundary = (pos_q == len_q - len_t'(1));
        new_len  = base + len_t'(carry);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            len_q     <= len_t'(1);
            clk_out   <= 1'b0;
            long_flag <= 1'b0;
        end else if (en) begin
            if (boundary) begin
                pos_q     <= '0;
                len_q     <= new_len;
                clk_out   <= (high_len(new_len) != '0);
                long_flag <= carry;
            end else begin
                pos_q     <= pos_q + len_t'(1);
                clk_out   <= ((pos_q + len_t'(1)) < high_len(len_q));
                long_flag <= 1'b0;
            end
        end else begin
            long_flag <= 1'b0;
        end
    end

    // R2: position never leaves the current period
    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        pos_q < len_q);
    // R4: output drops exactly at half the period
    a_r4_fall_at_half: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_out) |-> (pos_q == high_len(len_q)));
    // R6: frozen while disabled
    a_r6_hold_pos: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pos_q) && $stable(len_q));
    // R8: a started period is never shorter than the minimum
    a_r8_len_min: assert property (@(posedge clk) disable iff (rst)
        (en && boundary) |=> (len_q >= len_t'(MIN_INT)));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic             clk_out,
    output logic             long_flag
);
    logic boundary;
    logic carry;
    len_t base;

    assign base = base_len(div_int);

    fdiv_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .step  (en && boundary),
        .frac  (div_frac),
        .carry (carry)
    );

    fdiv_period u_period (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .base      (base),
        .carry     (carry),
        .boundary  (boundary),
        .clk_out   (clk_out),
        .long_flag (long_flag)
    );

    // R5: flag only at the first high cycle of a period
    a_r5_flag_on_rise: assert property (@(posedge clk) disable iff (rst)
        long_flag |-> (clk_out && !$past(clk_out)));
    // R6: output level holds while the gate is closed
    a_r6_out_stable: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(clk_out));
    // R6: flag silent while disabled
    a_r6_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> !long_flag);
endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] div_int  = 8'd6;
    logic [7:0] div_frac = 8'd0;
    logic       clk_out;
    logic       long_flag;

    int checks = 0;
    int errors = 0;
    int acc_m;

    always #2.5 clk = ~clk;

    frac_clk_div uut (
        .clk(clk), .rst(rst), .en(en),
        .div_int(div_int), .div_frac(div_frac),
        .clk_out(clk_out), .long_flag(long_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_n(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    // reference step: returns carry, updates model accumulator
    function automatic int model_step(input int f);
        int s;
        s = acc_m + f;
        acc_m = s % 256;
        return s / 256;
    endfunction

    // reset, then stop at the negedge showing the first high cycle
    task automatic start(input int n, input int f);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; div_int = 8'(n); div_frac = 8'(f);
        @(negedge clk);
        rst = 1'b0;
        acc_m = 0;
        while (clk_out !== 1'b1) @(negedge clk);
    endtask

    // called at a negedge in a first high cycle; ends at the next one
    task automatic measure(output int len, output int hi, output int flg);
        flg = long_flag;
        hi = 0; len = 0;
        while (clk_out === 1'b1) begin hi++; len++; @(negedge clk); end
        while (clk_out === 1'b0) begin len++; @(negedge clk); end
    endtask

    task automatic run_check(input string req, input int n, input int f, input int periods);
        int len, hi, flg, c;
        for (int i = 0; i < periods; i++) begin
            measure(len, hi, flg);
            c = model_step(f);
            check({req, " len"}, len, eff_n(n) + c);
            check("R4 high", hi, (eff_n(n) + c) / 2);
            check("R5 flag", flg, c);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len, hi, flg, tot;
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 clk_out reset", clk_out, 0);
        check("R1 flag reset", long_flag, 0);

        // R3: 6.25 pattern (also R1: first long period is the fourth)
        start(6, 64);
        for (int i = 0; i < 8; i++) begin
            measure(len, hi, flg);
            check("R3 pattern", len, (i % 4 == 3) ? 7 : 6);
        end

        // R9: zero fraction
        start(5, 0);
        run_check("R9", 5, 0, 6);

        // R8: small integer parts clamp
        start(0, 0);
        run_check("R8 n0", 0, 0, 4);
        start(1, 128);
        run_check("R8 n1", 1, 128, 6);

        // R2: random ratios
        for (int s = 0; s < 6; s++) begin
            int n, f;
            n = $urandom_range(20, 2);
            f = $urandom_range(255, 0);
            start(n, f);
            run_check("R2", n, f, 12);
        end

        // R6: freeze mid period (N=8, F=0)
        start(8, 0);
        repeat (2) @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R6 frozen out", clk_out, 1);
            check("R6 frozen flag", long_flag, 0);
        end
        en = 1'b1;
        measure(len, hi, flg);
        check("R6 resumed high", hi, 2);
        check("R6 resumed len", len, 6);

        // R7: change integer part mid period
        start(6, 0);
        repeat (2) @(negedge clk);
        div_int = 8'd10;
        measure(len, hi, flg);
        check("R7 current len kept", len, 4);
        measure(len, hi, flg);
        check("R7 new len at boundary", len, 10);

        // R10: 256-period sum
        start(3, 179);
        tot = 0;
        for (int i = 0; i < 256; i++) begin
            measure(len, hi, flg);
            tot += len;
        end
        check("R10 sum", tot, 256 * 3 + 179);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule